// File: doc/BRIEF.md
# Byte-Masked Write-Back Dirty Tracker

This block sits beside an 8 KB local read/write memory window. The CPU writes the window one byte at a time. Each write stores the byte locally and records it in a two-level dirty map: one bit for every byte of the window and one bit for every 64-bit word. While the CPU is not reading the window, a scanner walks the word map. For each dirty word it finds, it sends one 64-bit flush request to a larger backing store. The request carries a byte-enable mask built from that word's eight byte bits.

Flush requests use a valid/ready handshake. Only one request is outstanding at a time, and it stays unchanged until the backing side accepts it. On acceptance the word's dirty state is cleared. The exception is a CPU write that touched the same word while the request was in flight. In that case the word stays dirty, so the newer bytes are sent on a later pass.

Top module: `wb_dirty_tracker`

## Requirements
- R1: After reset no flush request is active and both dirty maps are empty. Until the CPU writes, `flush_valid` never rises.
- R2: A CPU byte write at address A marks byte A and word A[12:3] dirty. A[2:0] selects the byte lane, and lane k maps to `flush_mask[k]` and `flush_data[8k+7:8k]`. The word is later flushed with that lane enabled and carrying the written byte.
- R3: No new flush request is issued in the cycle after a cycle in which `cpu_rd_active` was high. The scan position does not advance while a read is active.
- R4: The scanner visits word indices in ascending order, one per idle cycle, and wraps from the last word to word 0. Dirty words are flushed in that visiting order.
- R5: While `flush_valid` is high and `flush_ready` is low, the request's word, data and mask stay unchanged.
- R6: `flush_mask` equals the word's byte-dirty bits at the moment of issue and is never zero. The data lanes carry the stored bytes. Lanes whose mask bit is clear read as zero.
- R7: On acceptance the word bit and its eight byte bits are cleared, and the word is not flushed again. The exception is a CPU write to that word between the issue cycle and the accept cycle, inclusive. In that case the word stays dirty with all its bits and is flushed again on a later pass.
- R8: If `cpu_rd_active` rises while a request is pending, that request still completes. No new request is issued until the read ends.
- R9: At most one request is outstanding. After an accepted request, `flush_valid` is low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | CPU byte write strobe |
| cpu_wr_addr | input | 13 | Byte address within the window |
| cpu_wr_data | input | 8 | Byte written |
| cpu_rd_active | input | 1 | High while the CPU reads the window |
| flush_valid | output | 1 | Flush request pending |
| flush_ready | input | 1 | Backing side accepts the request |
| flush_word | output | 10 | Word index of the flush |
| flush_data | output | 64 | Word data, unmasked lanes zero |
| flush_mask | output | 8 | Byte enables, one per lane |

## Verification
A CPU write updates the maps at the next edge. The scanner can then see it on the next cycle at the earliest, and a request is issued one edge after the scanner reaches that word. Acceptance happens on the edge where valid and ready are both high, and the clear takes effect at that same edge. The behavioural model in the bench applies each of these rules at every rising edge using the inputs held since the previous falling edge. The outputs are compared on the falling edge that follows, so every expected value is read exactly one register stage after its cause. Directed checks then confirm flush order, masks, stalls, re-dirtying and quiet periods against lists recorded from the ports.

// File: rtl/dtrk_pkg.sv
package dtrk_pkg;
  localparam int unsigned BYTE_W = 8;

  // Widen a lane mask into a bit mask over the whole word.
  function automatic logic [63:0] lane_bits(input logic [7:0] m);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[k*BYTE_W +: BYTE_W] = {BYTE_W{m[k]}};
    return r;
  endfunction
endpackage

// File: rtl/dtrk_dirty_map.sv
module dtrk_dirty_map #(
  parameter int unsigned NWORDS = 1024,
  parameter int unsigned LANES  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      set_en,
  input  logic [$clog2(NWORDS)-1:0] set_word,
  input  logic [$clog2(LANES)-1:0]  set_lane,
  input  logic                      clr_en,
  input  logic [$clog2(NWORDS)-1:0] clr_word,
  input  logic [$clog2(NWORDS)-1:0] look_word,
  output logic                      look_dirty,
  output logic [LANES-1:0]          look_lanes
);
  localparam int unsigned NBITS = NWORDS * LANES;

  logic [NWORDS-1:0] word_q, word_d;
  logic [NBITS-1:0]  byte_q, byte_d;
  logic              upd_en;

  assign upd_en = set_en | clr_en;

  always_comb begin
    word_d = word_q;
    byte_d = byte_q;
    if (clr_en) begin
      word_d[clr_word]                = 1'b0;
      byte_d[clr_word*LANES +: LANES] = '0;
    end
    // a write lands after the clear so it always survives
    if (set_en) begin
      word_d[set_word]                  = 1'b1;
      byte_d[set_word*LANES + set_lane] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      byte_q <= '0;
    end else if (upd_en) begin
      word_q <= word_d;
      byte_q <= byte_d;
    end
  end

  assign look_dirty = word_q[look_word];
  assign look_lanes = byte_q[look_word*LANES +: LANES];
endmodule

// File: rtl/dtrk_word_store.sv
module dtrk_word_store #(
  parameter int unsigned NWORDS = 1024,
  parameter int unsigned LANES  = 8
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [$clog2(NWORDS)-1:0]     wr_word,
  input  logic [$clog2(LANES)-1:0]      wr_lane,
  input  logic [dtrk_pkg::BYTE_W-1:0]   wr_byte,
  input  logic [$clog2(NWORDS)-1:0]     rd_word,
  output logic [LANES*dtrk_pkg::BYTE_W-1:0] rd_data
);
  localparam int unsigned WW = LANES * dtrk_pkg::BYTE_W;

  logic [WW-1:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_word][wr_lane*dtrk_pkg::BYTE_W +: dtrk_pkg::BYTE_W] <= wr_byte;
  end

  assign rd_data = mem[rd_word];
endmodule

// File: rtl/dtrk_flush_scan.sv
module dtrk_flush_scan #(
  parameter int unsigned NWORDS = 1024,
  parameter int unsigned LANES  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_active,
  input  logic                      wr_en,
  input  logic [$clog2(NWORDS)-1:0] wr_word,
  input  logic                      cur_dirty,
  input  logic [LANES-1:0]          cur_lanes,
  input  logic [LANES*8-1:0]        cur_data,
  input  logic                      req_ready,
  output logic [$clog2(NWORDS)-1:0] scan_ptr,
  output logic                      req_valid,
  output logic [$clog2(NWORDS)-1:0] req_word,
  output logic [LANES*8-1:0]        req_data,
  output logic [LANES-1:0]          req_mask,
  output logic                      clr_en,
  output logic [$clog2(NWORDS)-1:0] clr_word
);
  import dtrk_pkg::*;
  localparam int unsigned WIDX = $clog2(NWORDS);
  localparam int unsigned WW   = LANES * 8;
  localparam logic [WIDX-1:0] LAST = WIDX'(NWORDS - 1);

  logic [WIDX-1:0] ptr_q, ptr_d, idx_q;
  logic            pend_q, pend_d, hit_q, hit_d;
  logic [WW-1:0]   data_q;
  logic [LANES-1:0] mask_q;
  logic            go, issue, accept, hit_now, wr_tgt;
  logic [WIDX-1:0] tgt;

  always_comb begin
    go      = !pend_q && !rd_active;
    issue   = go && cur_dirty;
    accept  = pend_q && req_ready;
    tgt     = pend_q ? idx_q : ptr_q;
    wr_tgt  = wr_en && (wr_word == tgt);
    hit_now = pend_q ? (hit_q | wr_tgt) : wr_tgt;
    pend_d  = issue | (pend_q & ~accept);
    hit_d   = pend_d ? hit_now : 1'b0;
    ptr_d   = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    clr_en  = accept && !hit_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
      hit_q  <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      hit_q  <= hit_d;
      if (go) ptr_q <= ptr_d;
      if (issue) begin
        idx_q  <= ptr_q;
        mask_q <= cur_lanes;
        data_q <= cur_data & lane_bits(8'(cur_lanes));
      end
    end
  end

  assign scan_ptr  = ptr_q;
  assign req_valid = pend_q;
  assign req_word  = idx_q;
  assign req_data  = data_q;
  assign req_mask  = mask_q;
  assign clr_word  = idx_q;
endmodule

// File: rtl/wb_dirty_tracker.sv
module wb_dirty_tracker #(
  parameter int unsigned WIN_BYTES = 8192,
  parameter int unsigned LANES     = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cpu_wr_en,
  input  logic [$clog2(WIN_BYTES)-1:0]          cpu_wr_addr,
  input  logic [7:0]                            cpu_wr_data,
  input  logic                                  cpu_rd_active,
  output logic                                  flush_valid,
  input  logic                                  flush_ready,
  output logic [$clog2(WIN_BYTES/LANES)-1:0]    flush_word,
  output logic [LANES*8-1:0]                    flush_data,
  output logic [LANES-1:0]                      flush_mask
);
  localparam int unsigned NWORDS = WIN_BYTES / LANES;
  localparam int unsigned WIDX   = $clog2(NWORDS);
  localparam int unsigned LBITS  = $clog2(LANES);
  localparam int unsigned ABITS  = $clog2(WIN_BYTES);

  logic [WIDX-1:0]    wr_word, scan_ptr, clr_word;
  logic [LBITS-1:0]   wr_lane;
  logic               cur_dirty, clr_en;
  logic [LANES-1:0]   cur_lanes;
  logic [LANES*8-1:0] cur_data;

  assign wr_word = cpu_wr_addr[ABITS-1:LBITS];
  assign wr_lane = cpu_wr_addr[LBITS-1:0];

  dtrk_dirty_map #(.NWORDS(NWORDS), .LANES(LANES)) u_map (
    .clk(clk), .rst_n(rst_n),
    .set_en(cpu_wr_en), .set_word(wr_word), .set_lane(wr_lane),
    .clr_en(clr_en), .clr_word(clr_word),
    .look_word(scan_ptr), .look_dirty(cur_dirty), .look_lanes(cur_lanes)
  );

  dtrk_word_store #(.NWORDS(NWORDS), .LANES(LANES)) u_store (
    .clk(clk), .wr_en(cpu_wr_en), .wr_word(wr_word), .wr_lane(wr_lane),
    .wr_byte(cpu_wr_data), .rd_word(scan_ptr), .rd_data(cur_data)
  );

  dtrk_flush_scan #(.NWORDS(NWORDS), .LANES(LANES)) u_scan (
    .clk(clk), .rst_n(rst_n), .rd_active(cpu_rd_active),
    .wr_en(cpu_wr_en), .wr_word(wr_word),
    .cur_dirty(cur_dirty), .cur_lanes(cur_lanes), .cur_data(cur_data),
    .req_ready(flush_ready), .scan_ptr(scan_ptr),
    .req_valid(flush_valid), .req_word(flush_word), .req_data(flush_data),
    .req_mask(flush_mask), .clr_en(clr_en), .clr_word(clr_word)
  );
endmodule

// File: rtl/dtrk_chk.sv
module dtrk_chk #(
  parameter int unsigned WIDX  = 10,
  parameter int unsigned LANES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_active,
  input logic               valid,
  input logic               ready,
  input logic [WIDX-1:0]    word,
  input logic [LANES*8-1:0] data,
  input logic [LANES-1:0]   mask
);
  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(word) && $stable(data) && $stable(mask));

  // R9
  gap_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready |=> !valid);

  // R3
  no_issue_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && rd_active |=> !valid);

  // R6
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> mask != '0);
endmodule

bind wb_dirty_tracker dtrk_chk #(.WIDX($clog2(WIN_BYTES/LANES)), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_active(cpu_rd_active), .valid(flush_valid),
  .ready(flush_ready), .word(flush_word), .data(flush_data), .mask(flush_mask)
);

// File: tb/sim_wb_dirty_tracker.sv
module sim_wb_dirty_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_act = 1'b0, ready = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        valid;
  logic [9:0]  fword;
  logic [63:0] fdata;
  logic [7:0]  fmask;

  int tests = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_dirty_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(wr_en), .cpu_wr_addr(wr_addr),
    .cpu_wr_data(wr_data), .cpu_rd_active(rd_act), .flush_valid(valid),
    .flush_ready(ready), .flush_word(fword), .flush_data(fdata), .flush_mask(fmask)
  );

  // behavioural reference: plain arrays and integers
  bit        m_wd [NW];
  bit [7:0]  m_bd [NW];
  bit [7:0]  m_mem [NW*8];
  int        m_ptr, m_idx;
  bit        m_pend, m_hit;
  bit [7:0]  m_be;
  bit [63:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_wd[i]) begin m_wd[i] = 0; m_bd[i] = 0; end
      m_ptr = 0; m_pend = 0; m_hit = 0; m_idx = 0; m_be = 0; m_data = 0;
    end else begin
      bit go, iss, acc, hitnow; int ww;
      ww = int'(wr_addr) / 8;
      go = !m_pend && !rd_act;
      iss = go && m_wd[m_ptr];
      acc = m_pend && ready;
      hitnow = m_pend ? (m_hit || (wr_en && ww == m_idx)) : (wr_en && ww == m_ptr);
      if (acc && !hitnow) begin m_wd[m_idx] = 0; m_bd[m_idx] = 0; end
      if (iss) begin
        m_idx = m_ptr; m_be = m_bd[m_ptr]; m_data = 0;
        for (int k = 0; k < 8; k++)
          if (m_be[k]) m_data[8*k +: 8] = m_mem[m_ptr*8 + k];
      end
      m_pend = iss || (m_pend && !acc);
      m_hit  = m_pend ? hitnow : 0;
      if (go) m_ptr = (m_ptr + 1) % NW;
      if (wr_en) begin
        m_wd[ww] = 1; m_bd[ww][wr_addr[2:0]] = 1; m_mem[wr_addr] = wr_data;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison and flush log
  int        acc_word[$];
  bit [7:0]  acc_mask[$];
  bit [63:0] acc_data[$];
  int        issue_cnt = 0;
  bit        prev_valid = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(valid === m_pend, "R9 valid vs model", 64'(valid), 64'(m_pend));
      if (m_pend) begin
        chk(fword === 10'(m_idx), "R4 word vs model", 64'(fword), 64'(m_idx));
        chk(fmask === m_be, "R6 mask vs model", 64'(fmask), 64'(m_be));
        chk(fdata === m_data, "R6 data vs model", fdata, m_data);
      end
      if (valid && !prev_valid) issue_cnt++;
      if (valid && ready) begin
        acc_word.push_back(int'(fword)); acc_mask.push_back(fmask); acc_data.push_back(fdata);
      end
      prev_valid = valid;
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 13'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 1200 && !valid; i++) @(negedge clk);
  endtask

  initial begin
    step(3);
    chk(valid === 1'b0, "R1 valid in reset", 64'(valid), 0);
    rst_n = 1; ready = 1;
    step(1);
    chk(valid === 1'b0, "R1 valid after reset", 64'(valid), 0);
    step(1100);
    chk(issue_cnt == 0, "R1 no flush without writes", 64'(issue_cnt), 0);

    // writes under an active read: nothing issued
    @(negedge clk); rd_act = 1;
    cpu_write(40, 8'hA1); cpu_write(45, 8'hB6);
    cpu_write(31, 8'hC7); cpu_write(8186, 8'hD2);
    step(1100);
    chk(issue_cnt == 0, "R3 no flush while reading", 64'(issue_cnt), 0);
    rd_act = 0;
    step(1100);
    chk(acc_word.size() == 3, "R2 three words flushed", 64'(acc_word.size()), 3);
    begin
      int desc = 0;
      for (int i = 1; i < acc_word.size(); i++) if (acc_word[i] < acc_word[i-1]) desc++;
      chk(desc <= 1, "R4 ascending with one wrap", 64'(desc), 1);
    end
    foreach (acc_word[i]) begin
      if (acc_word[i] == 5) begin
        chk(acc_mask[i] == 8'h21, "R6 word5 mask lanes 0,5", 64'(acc_mask[i]), 64'h21);
        chk(acc_data[i] == 64'h0000_B600_0000_00A1, "R6 word5 data", acc_data[i], 64'h0000_B600_0000_00A1);
      end
      if (acc_word[i] == 3)
        chk(acc_data[i] == 64'hC700_0000_0000_0000 && acc_mask[i] == 8'h80, "R2 word3 lane7", acc_data[i], 64'hC700_0000_0000_0000);
      if (acc_word[i] == 1023)
        chk(acc_mask[i] == 8'h04, "R2 word1023 lane2", 64'(acc_mask[i]), 64'h04);
    end

    // backpressure and re-dirtying of the pending word
    acc_word.delete(); acc_mask.delete(); acc_data.delete();
    ready = 0;
    cpu_write(100*8 + 1, 8'h11);
    wait_valid();
    step(20);
    chk(valid === 1'b1 && fword == 10'd100, "R5 request held", 64'(fword), 100);
    cpu_write(100*8 + 3, 8'h33);
    chk(fmask === 8'h02, "R5 mask unchanged by new write", 64'(fmask), 64'h02);
    ready = 1;
    step(1100);
    chk(acc_word.size() == 2, "R7 re-dirtied word flushed twice", 64'(acc_word.size()), 2);
    if (acc_word.size() == 2)
      chk(acc_mask[1] == 8'h0A && acc_data[1] == 64'h0000_0000_3300_1100, "R7 second flush lanes 1,3", acc_data[1], 64'h0000_0000_3300_1100);

    // write to the word in the very cycle it is accepted
    acc_word.delete(); acc_mask.delete(); acc_data.delete();
    ready = 0;
    cpu_write(300*8, 8'h5A);
    wait_valid();
    @(negedge clk); ready = 1; wr_en = 1; wr_addr = 13'(300*8 + 7); wr_data = 8'hE7;
    @(negedge clk); ready = 1; wr_en = 0;
    step(1100);
    chk(acc_word.size() == 2, "R7 same-cycle write keeps word dirty", 64'(acc_word.size()), 2);
    if (acc_word.size() == 2)
      chk(acc_mask[1] == 8'h81, "R7 kept bits plus new lane", 64'(acc_mask[1]), 64'h81);

    // read begins while a request is pending
    acc_word.delete(); acc_mask.delete(); acc_data.delete();
    ready = 0;
    cpu_write(200*8, 8'h20);
    wait_valid();
    cpu_write(201*8, 8'h21);
    @(negedge clk); rd_act = 1; ready = 1;
    step(60);
    chk(acc_word.size() == 1 && valid === 1'b0, "R8 pending finishes, no new issue", 64'(acc_word.size()), 1);
    rd_act = 0;
    step(1100);
    chk(acc_word.size() == 2 && acc_word[acc_word.size()-1] == 201, "R8 held word flushed after read", 64'(acc_word.size()), 2);

    // everything clean now: a full pass stays quiet
    issue_cnt = 0;
    step(1100);
    chk(issue_cnt == 0, "R7 accepted words stay clean", 64'(issue_cnt), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule